// File: doc/BRIEF.md
# Debug Halt Request Arbiter

This block decides when a processor core stops and enters debug state. Two kinds of cause reach it. Software debug events come from the core: a vector catch, a breakpoint hit, a watchpoint hit and an executed breakpoint instruction. They halt the core only when halting mode is selected. Otherwise they go back out as a debug-exception request. Forced requests are the external debug request and a halt command decoded from the test access port. They halt the core whenever debug is enabled, whatever the mode field holds, so a debugger can stop the core straight after reset.

The TAP halt command counts only while the TAP controller sits in Run-Test/Idle. A forced request that arrives while debug is not permitted is held until it is. On entry the block sets a core-halted status bit and raises three controls: freeze the program counter, mask interrupts, and fetch from the instruction transfer register. It also records a 3-bit cause code. A restart input leaves debug state one cycle later. All pins are plain control and status levels, so there is no valid/ready traffic and no back-pressure.

Top module: `dbg_halt_arb`

## Requirements
- R1: After reset, core_halted, halt_req, pc_freeze, irq_mask, fetch_itr, dbg_exc_req and moe are all zero.
- R2: With dbg_en=1, dbg_permit=1 and mode_sel[0]=1 (halting mode), any software event (ev_vcatch, ev_bkpt, ev_wpt, ev_bkpt_insn) sets core_halted on the next clock edge.
- R3: With dbg_en=1, dbg_permit=1 and mode_sel[0]=0, a software event raises dbg_exc_req for one cycle, one edge later, and does not halt the core. dbg_exc_req stays low while halted, and also stays low when a halt is taken on the same edge.
- R4: tap_halt is honoured only while tap_state equals TAP_IDLE_CODE (4'hC, Run-Test/Idle). In any other state it has no effect.
- R5: ext_req, or a tap_halt honoured under R4, halts the core on the next edge when dbg_en=1 and dbg_permit=1, for every value of mode_sel.
- R6: With dbg_en=0 nothing halts the core and dbg_exc_req stays low. Any held forced request is discarded.
- R7: A forced request seen while dbg_en=1 and dbg_permit=0 is held. It halts the core on the edge after dbg_permit becomes 1, even though the request input has since dropped.
- R8: While core_halted=1, pc_freeze, irq_mask and fetch_itr are 1. halt_req is 1 for exactly the first cycle of each halt.
- R9: moe is captured on the halt edge and holds until the next halt. Codes, highest priority first: 1 TAP halt, 2 external request, 3 breakpoint hit, 4 breakpoint instruction, 5 vector catch, 6 watchpoint.
- R10: restart while halted clears core_halted and the controls on the next edge. A forced request arriving in the restart cycle halts the core one cycle after that, with core_halted low for exactly one cycle in between.
- R11: restart while not halted has no effect. A forced request arriving while halted, outside the restart cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_en | input | 1 | Debug enable |
| dbg_permit | input | 1 | Debug permitted in current core state |
| mode_sel | input | 2 | Debug mode field; bit 0 selects halting mode |
| ev_vcatch | input | 1 | Vector catch event |
| ev_bkpt | input | 1 | Breakpoint hit |
| ev_wpt | input | 1 | Watchpoint hit |
| ev_bkpt_insn | input | 1 | Breakpoint instruction executed |
| ext_req | input | 1 | External debug request |
| tap_halt | input | 1 | Halt command decoded from TAP instruction |
| tap_state | input | 4 | Current TAP controller state code |
| restart | input | 1 | Leave debug state |
| halt_req | output | 1 | One-cycle halt request to core |
| core_halted | output | 1 | Core-halted status bit |
| pc_freeze | output | 1 | Stop program counter increment |
| irq_mask | output | 1 | Ignore interrupts |
| fetch_itr | output | 1 | Fetch from instruction transfer register |
| dbg_exc_req | output | 1 | Debug-exception request for software events |
| moe | output | 3 | Method-of-entry cause code |

## Verification
On every cycle the assertions check four things. A halt never begins without debug enabled and permitted. The freeze, mask and fetch controls follow the halted state, and halt_req marks only the first halted cycle. A restart always leaves debug state on the next edge. The cause code never changes during a halt, and no debug exception is raised while halted.

The bench alone can show the rest. It sweeps every combination of enables, mode field, events, forced requests and TAP state from a clean start, which checks the mode split, the Run-Test/Idle gating and the cause priority. Directed scenarios cover a request held until debug is permitted, a request deferred across a restart, and requests ignored while halted.

// File: rtl/dha_pkg.sv
package dha_pkg;
  localparam int MOE_W = 3;
  localparam int N_SRC = 6;
  typedef logic [MOE_W-1:0] moe_t;
  // source index order is the priority order, index 0 highest
  localparam int SRC_TAP  = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_BKPT = 2;
  localparam int SRC_BINS = 3;
  localparam int SRC_VCAT = 4;
  localparam int SRC_WPT  = 5;
endpackage

// File: rtl/dha_tap_gate.sv
module dha_tap_gate #(
  parameter int TAP_STATE_W = 4,
  parameter logic [TAP_STATE_W-1:0] TAP_IDLE_CODE = 4'hC
) (
  input  logic                   tap_halt,
  input  logic [TAP_STATE_W-1:0] tap_state,
  output logic                   tap_go
);
  always_comb tap_go = tap_halt && (tap_state == TAP_IDLE_CODE);
endmodule

// File: rtl/dha_pend.sv
module dha_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_new,
  input  logic         allow_set,
  input  logic         clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       held_q <= 1'b0;
      else if (clr)                     held_q <= 1'b0;
      else if (allow_set && req_new[i]) held_q <= 1'b1;
    end
    assign pend[i] = held_q;
  end
endmodule

// File: rtl/dha_prio.sv
module dha_prio #(
  parameter int N = 6,
  parameter int CODE_W = 3
) (
  input  logic [N-1:0]      req,
  output logic              any,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    any  = |req;
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/dha_state.sv
module dha_state #(
  parameter int MOE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [MOE_W-1:0] take_code,
  input  logic             restart,
  input  logic             exc_ev,
  output logic             halted,
  output logic             halt_pulse,
  output logic             exc_req,
  output logic [MOE_W-1:0] moe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted     <= 1'b0;
      halt_pulse <= 1'b0;
      exc_req    <= 1'b0;
      moe        <= '0;
    end else begin
      halt_pulse <= take;
      exc_req    <= exc_ev && !take && !halted;
      if (take) begin
        halted <= 1'b1;
        moe    <= take_code;
      end else if (halted && restart) begin
        halted <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_halt_arb.sv
module dbg_halt_arb #(
  parameter int TAP_STATE_W = 4,
  parameter logic [TAP_STATE_W-1:0] TAP_IDLE_CODE = 4'hC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dbg_en,
  input  logic                   dbg_permit,
  input  logic [1:0]             mode_sel,
  input  logic                   ev_vcatch,
  input  logic                   ev_bkpt,
  input  logic                   ev_wpt,
  input  logic                   ev_bkpt_insn,
  input  logic                   ext_req,
  input  logic                   tap_halt,
  input  logic [TAP_STATE_W-1:0] tap_state,
  input  logic                   restart,
  output logic                   halt_req,
  output logic                   core_halted,
  output logic                   pc_freeze,
  output logic                   irq_mask,
  output logic                   fetch_itr,
  output logic                   dbg_exc_req,
  output logic [2:0]             moe
);
  import dha_pkg::*;

  localparam int N_FORCED = 2;

  logic                tap_go;
  logic [N_FORCED-1:0] forced_new, forced_pend, forced_live;
  logic                halt_mode, sw_any, can_take, pend_allow;
  logic [N_SRC-1:0]    src_req;
  logic                any_req, take;
  moe_t                take_code;
  logic                halted;

  dha_tap_gate #(.TAP_STATE_W(TAP_STATE_W), .TAP_IDLE_CODE(TAP_IDLE_CODE)) u_tap (
    .tap_halt (tap_halt),
    .tap_state(tap_state),
    .tap_go   (tap_go)
  );

  always_comb begin
    forced_new = {ext_req, tap_go};
    halt_mode  = mode_sel[0];
    sw_any     = ev_vcatch | ev_bkpt | ev_wpt | ev_bkpt_insn;
    can_take   = dbg_en && dbg_permit && !halted;
    pend_allow = dbg_en && (!halted || restart);
    forced_live = forced_pend | (forced_new & {N_FORCED{dbg_en && !halted}});
  end

  dha_pend #(.N(N_FORCED)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_new  (forced_new),
    .allow_set(pend_allow),
    .clr      (take || !dbg_en),
    .pend     (forced_pend)
  );

  always_comb begin
    src_req           = '0;
    src_req[SRC_TAP]  = forced_live[0];
    src_req[SRC_EXT]  = forced_live[1];
    src_req[SRC_BKPT] = halt_mode && ev_bkpt;
    src_req[SRC_BINS] = halt_mode && ev_bkpt_insn;
    src_req[SRC_VCAT] = halt_mode && ev_vcatch;
    src_req[SRC_WPT]  = halt_mode && ev_wpt;
  end

  dha_prio #(.N(N_SRC), .CODE_W(MOE_W)) u_prio (
    .req (src_req),
    .any (any_req),
    .code(take_code)
  );

  always_comb take = can_take && any_req;

  dha_state #(.MOE_W(MOE_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_code (take_code),
    .restart   (restart),
    .exc_ev    (dbg_en && dbg_permit && !halt_mode && sw_any),
    .halted    (halted),
    .halt_pulse(halt_req),
    .exc_req   (dbg_exc_req),
    .moe       (moe)
  );

  always_comb begin
    core_halted = halted;
    pc_freeze   = halted;
    irq_mask    = halted;
    fetch_itr   = halted;
  end
endmodule

// File: rtl/dbg_halt_arb_chk.sv
module dbg_halt_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dbg_en,
  input logic       dbg_permit,
  input logic       restart,
  input logic       halt_req,
  input logic       core_halted,
  input logic       pc_freeze,
  input logic       irq_mask,
  input logic       fetch_itr,
  input logic       dbg_exc_req,
  input logic [2:0] moe
);
  AST_ENTRY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halted) |-> $past(dbg_en && dbg_permit)); // R6
  AST_CONTROLS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    core_halted |-> (pc_freeze && irq_mask && fetch_itr)); // R8
  AST_REQ_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (core_halted && !$past(core_halted))); // R8
  AST_RESTART_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halted && restart) |=> !core_halted); // R10
  AST_MOE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halted && $past(core_halted)) |-> $stable(moe)); // R9
  AST_NO_EXC_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_exc_req && core_halted)); // R3
endmodule

bind dbg_halt_arb dbg_halt_arb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dbg_en     (dbg_en),
  .dbg_permit (dbg_permit),
  .restart    (restart),
  .halt_req   (halt_req),
  .core_halted(core_halted),
  .pc_freeze  (pc_freeze),
  .irq_mask   (irq_mask),
  .fetch_itr  (fetch_itr),
  .dbg_exc_req(dbg_exc_req),
  .moe        (moe)
);

// File: tb/dbg_halt_arb_tb_top.sv
module dbg_halt_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_en = 0, dbg_permit = 0, ev_vcatch = 0, ev_bkpt = 0, ev_wpt = 0, ev_bkpt_insn = 0;
  logic ext_req = 0, tap_halt = 0, restart = 0;
  logic [1:0] mode_sel = 0;
  logic [3:0] tap_state = 4'h2;
  logic halt_req, core_halted, pc_freeze, irq_mask, fetch_itr, dbg_exc_req;
  logic [2:0] moe;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_halt_arb dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .dbg_permit(dbg_permit),
    .mode_sel(mode_sel), .ev_vcatch(ev_vcatch), .ev_bkpt(ev_bkpt), .ev_wpt(ev_wpt),
    .ev_bkpt_insn(ev_bkpt_insn), .ext_req(ext_req), .tap_halt(tap_halt),
    .tap_state(tap_state), .restart(restart), .halt_req(halt_req),
    .core_halted(core_halted), .pc_freeze(pc_freeze), .irq_mask(irq_mask),
    .fetch_itr(fetch_itr), .dbg_exc_req(dbg_exc_req), .moe(moe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dbg_en = 0; dbg_permit = 0; mode_sel = 0; ev_vcatch = 0; ev_bkpt = 0;
    ev_wpt = 0; ev_bkpt_insn = 0; ext_req = 0; tap_halt = 0; tap_state = 4'h2; restart = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clean();
    idle_inputs(); step();
    restart = 1; step();
    restart = 0; step();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 halted", core_halted, 0); chk("R1 req", halt_req, 0);
    chk("R1 ctl", {pc_freeze, irq_mask, fetch_itr}, 0);
    chk("R1 exc", dbg_exc_req, 0); chk("R1 moe", moe, 0);
    rst_n = 1; step();

    // sweep: R2 R3 R4 R5 R6 R8 R9
    for (int v = 0; v < 2048; v++) begin
      bit en, pm, hm, vc, bk, wp, bi, ex, th, idl, tapok, take, exc;
      int emoe;
      en = v[0]; pm = v[1]; mode_sel = v[3:2]; hm = v[2];
      vc = v[4]; bk = v[5]; wp = v[6]; bi = v[7]; ex = v[8]; th = v[9]; idl = v[10];
      dbg_en = en; dbg_permit = pm; ev_vcatch = vc; ev_bkpt = bk; ev_wpt = wp;
      ev_bkpt_insn = bi; ext_req = ex; tap_halt = th; tap_state = idl ? 4'hC : 4'h2;
      tapok = th && idl;
      emoe = tapok ? 1 : ex ? 2 : (hm && bk) ? 3 : (hm && bi) ? 4 : (hm && vc) ? 5 : (hm && wp) ? 6 : 0;
      take = en && pm && (emoe != 0);
      exc = en && pm && !hm && (vc || bk || wp || bi) && !take;
      step();
      chk("R2 R4 R5 R6 halted", core_halted, take);
      chk("R8 halt_req", halt_req, take);
      chk("R8 controls", {pc_freeze, irq_mask, fetch_itr}, take ? 7 : 0);
      chk("R3 exc", dbg_exc_req, exc);
      if (take) chk("R9 moe", moe, emoe);
      clean();
    end

    // R7 held request
    dbg_en = 1; dbg_permit = 0; ext_req = 1; step();
    ext_req = 0; step(); step();
    chk("R7 held not halted", core_halted, 0);
    dbg_permit = 1; step();
    chk("R7 halted after permit", core_halted, 1);
    chk("R7 moe", moe, 2);

    // R11 forced request while halted ignored; R9 moe held
    tap_halt = 1; tap_state = 4'hC; step();
    tap_halt = 0; tap_state = 4'h2;
    chk("R9 moe held", moe, 2);
    restart = 1; step();
    restart = 0;
    chk("R10 restart exits", core_halted, 0);
    step(); step();
    chk("R11 ignored while halted", core_halted, 0);

    // R11 restart while not halted
    restart = 1; step(); restart = 0;
    chk("R11 restart idle", core_halted, 0);
    chk("R11 restart idle req", halt_req, 0);

    // R10 deferral across restart
    ext_req = 1; step(); ext_req = 0;
    chk("R10 setup halted", core_halted, 1);
    restart = 1; ext_req = 1; step();
    restart = 0; ext_req = 0;
    chk("R10 one cycle out", core_halted, 0);
    step();
    chk("R10 deferred halt", core_halted, 1);
    chk("R10 deferred pulse", halt_req, 1);
    step();
    chk("R8 pulse one cycle", halt_req, 0);

    // R6 dropping enable discards held request
    restart = 1; step(); restart = 0;
    dbg_permit = 0; ext_req = 1; step(); ext_req = 0;
    dbg_en = 0; step();
    dbg_en = 1; dbg_permit = 1; step();
    chk("R6 held discarded", core_halted, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule